// File: doc/BRIEF.md
# Infrared Receive Sampler with Run-Length FIFO

This block receives the demodulated output of an infrared remote-control detector. It samples that input once every programmable number of clock cycles. It turns the stream of samples into run-length bytes: the top bit gives the polarity (carrier present or absent) and the low seven bits give how many samples the run lasted. It then pushes those bytes into a receive FIFO that software drains through a small register interface.

A run of silence after a burst is counted in samples. When that count reaches a 16-bit limit, the block closes the packet with a terminator byte and raises a packet-end status bit. Status bits are also raised when a byte is stored, when the FIFO reaches a selectable trigger level, and when a byte is lost to a full FIFO. Each status bit is cleared by writing one to it. A single interrupt line goes high while any status bit is set and its matching enable bit is set.

The register map uses these offsets on `bus_addr`:

| Offset | Register | Access |
|---|---|---|
| 0 | control | read/write |
| 1 | sample period | read/write |
| 2 | status | read, write-one-to-clear |
| 3 | interrupt enable | read/write |
| 4 | FIFO control | read/write |
| 5 | limit high byte | read/write |
| 6 | limit low byte | read/write |
| 7 | FIFO count | read-only |
| 8 | FIFO data | read-only; a read strobe pops |

Top module: `ir_rx_sampler`

## Requirements
- R1: After reset, the FIFO count reads 0, status reads 0x00, the control register reads 0x00 and `irq` is low.
- R2: Each stored byte has bit 7 = 1 for a carrier-present run and 0 for a carrier-absent run, and bits 6:0 = run length in samples. A run is emitted when the sampled polarity changes. Reception starts idle and the first run begins at the first carrier-present sample.
- R3: When a run reaches 127 samples and continues, a byte with length 0x7F is emitted and counting restarts at 1 for the rest of the run.
- R4: A carrier-absent run whose sample count reaches the 16-bit limit (high byte at offset 5, low byte at offset 6) emits 0x80 in place of the pending absent-run byte. It also sets status bit 5 and returns the receiver to idle. A limit of 0 never ends a packet.
- R5: Sampling happens only while control bit 0 is set. The sample-period register value P gives one sample every P+1 clocks. While reception is disabled no byte is stored.
- R6: With control bit 2 set, a low input is treated as carrier present.
- R7: The FIFO holds 32 bytes. Offset 7 reads the occupancy. Each read strobe at offset 8 returns the oldest byte and removes it. A read strobe on an empty FIFO leaves the count at 0.
- R8: A byte produced while the FIFO holds 32 bytes is dropped and sets status bit 4. Every produced byte, stored or dropped, sets status bit 7.
- R9: Status bit 6 is set when a stored byte brings the occupancy to at least the trigger level. FIFO control bits 3:2 select the level: 0 gives 1, 1 gives 8, 2 gives 16, 3 gives 24.
- R10: Writing a 1 to a status bit clears it and leaves the other bits unchanged; a bit set in the same cycle stays set. Status bits 3:0 always read 0.
- R11: `irq` is high exactly while some status bit and the same interrupt-enable bit (offset 3) are both 1.
- R12: Writing FIFO control with bit 0 set empties the FIFO. FIFO control reads back bits 7:2 as written and bits 1:0 as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_in | input | 1 | Demodulated infrared input, asynchronous |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops at offset 8) |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request, active high |

## Verification
A wrong run-length counter or polarity register shows up in the byte sequence read from the data register. The first sign is the byte that closes the broken run, which is stored four clocks after that run ends at the pin: two synchronizer stages, the encoder register and the FIFO write. A stuck terminator counter shows up in two ways: the 0x80 byte and the packet-end status bit are missing, and the count register keeps its value once the silence passes the limit. Faults in the FIFO pointers or in the status logic are visible on the very next register read, as a wrong occupancy, a byte out of order, or an `irq` level that disagrees with status and enable.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;

    // register offsets
    localparam logic [3:0] A_CTRL   = 4'd0;
    localparam logic [3:0] A_PERIOD = 4'd1;
    localparam logic [3:0] A_STATUS = 4'd2;
    localparam logic [3:0] A_IEN    = 4'd3;
    localparam logic [3:0] A_FCTRL  = 4'd4;
    localparam logic [3:0] A_LIMHI  = 4'd5;
    localparam logic [3:0] A_LIMLO  = 4'd6;
    localparam logic [3:0] A_COUNT  = 4'd7;
    localparam logic [3:0] A_DATA   = 4'd8;

    // status bit positions
    localparam int ST_RDR = 7;
    localparam int ST_RTR = 6;
    localparam int ST_PE  = 5;
    localparam int ST_RFO = 4;

    // run-length byte format
    localparam int          LEN_W    = 7;
    localparam logic [7:0]  END_CODE = 8'h80;

endpackage

// File: rtl/ir_rx_sync.sv
module ir_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/ir_rx_rle.sv
module ir_rx_rle
    import ir_rx_pkg::*;
#(
    parameter int PER_W = 8,
    parameter int LIM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PER_W-1:0] period,
    input  logic             carrier,
    input  logic [LIM_W-1:0] limit,
    output logic             push,
    output logic [7:0]       byte_o,
    output logic             pkt_end
);
    localparam logic [LEN_W-1:0] LEN_MAX = '1;

    typedef struct packed {
        logic [PER_W-1:0] tmr;
        logic             active;
        logic             pol;
        logic [LEN_W-1:0] len;
        logic [LIM_W-1:0] scnt;
        logic             push;
        logic [7:0]       data;
        logic             pend;
    } rle_t;

    rle_t s_d, s_q;
    logic             tick;
    logic [LIM_W-1:0] scnt_inc;

    always_comb begin
        s_d      = s_q;
        s_d.push = 1'b0;
        s_d.pend = 1'b0;
        tick     = (s_q.tmr == period);
        scnt_inc = (s_q.scnt == '1) ? s_q.scnt : s_q.scnt + 1'b1;

        if (!en) begin
            s_d.tmr    = '0;
            s_d.active = 1'b0;
            s_d.pol    = 1'b0;
            s_d.len    = '0;
            s_d.scnt   = '0;
        end else begin
            s_d.tmr = tick ? '0 : s_q.tmr + 1'b1;
            if (tick) begin
                if (!s_q.active) begin
                    if (carrier) begin
                        s_d.active = 1'b1;
                        s_d.pol    = 1'b1;
                        s_d.len    = LEN_W'(1);
                        s_d.scnt   = '0;
                    end
                end else if (carrier == s_q.pol) begin
                    if (!s_q.pol) s_d.scnt = scnt_inc;
                    if (!s_q.pol && (limit != '0) && (scnt_inc >= limit)) begin
                        // silence long enough: close the packet
                        s_d.push   = 1'b1;
                        s_d.data   = END_CODE;
                        s_d.pend   = 1'b1;
                        s_d.active = 1'b0;
                        s_d.len    = '0;
                        s_d.scnt   = '0;
                    end else if (s_q.len == LEN_MAX) begin
                        s_d.push = 1'b1;
                        s_d.data = {s_q.pol, LEN_MAX};
                        s_d.len  = LEN_W'(1);
                    end else begin
                        s_d.len = s_q.len + 1'b1;
                    end
                end else begin
                    s_d.push = 1'b1;
                    s_d.data = {s_q.pol, s_q.len};
                    s_d.pol  = carrier;
                    s_d.len  = LEN_W'(1);
                    s_d.scnt = carrier ? '0 : LIM_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign push    = s_q.push;
    assign byte_o  = s_q.data;
    assign pkt_end = s_q.pend;
endmodule

// File: rtl/ir_rx_fifo.sv
module ir_rx_fifo #(
    parameter int DEPTH = 32,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          full
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_t;

    fifo_t f_d, f_q;
    logic [W-1:0] mem [DEPTH];
    logic do_push, do_pop;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        full    = (f_q.cnt == CW'(DEPTH));
        do_push = push && !full && !clr;
        do_pop  = pop && (f_q.cnt != '0) && !clr;
        f_d     = f_q;
        if (clr) begin
            f_d = '0;
        end else begin
            if (do_push) f_d.wp = nxt(f_q.wp);
            if (do_pop)  f_d.rp = nxt(f_q.rp);
            case ({do_push, do_pop})
                2'b10:   f_d.cnt = f_q.cnt + 1'b1;
                2'b01:   f_d.cnt = f_q.cnt - 1'b1;
                default: f_d.cnt = f_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[f_q.wp] <= din;
    end

    assign dout  = mem[f_q.rp];
    assign count = f_q.cnt;
endmodule

// File: rtl/ir_rx_sampler.sv
module ir_rx_sampler
    import ir_rx_pkg::*;
#(
    parameter int DEPTH       = 32,
    parameter int SYNC_STAGES = 2,
    localparam int CW         = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ir_in,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [3:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq
);
    typedef struct packed {
        logic [7:0]  ctrl;
        logic [7:0]  period;
        logic [7:0]  sts;
        logic [7:0]  ien;
        logic [7:0]  fctrl;
        logic [15:0] limit;
    } regs_t;

    regs_t r_d, r_q;

    logic          ir_sync, carrier;
    logic          rle_push, rle_end;
    logic [7:0]    rle_byte;
    logic          fifo_clr, fifo_pop, fifo_full;
    logic [7:0]    fifo_dout;
    logic [CW-1:0] fifo_cnt;
    logic [CW-1:0] trig_lvl;
    logic [7:0]    sts_set, sts_clr;
    logic          rx_en;
    logic [7:0]    sts_now;

    ir_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst_n(rst_n),
        .d   (ir_in),
        .q   (ir_sync)
    );

    assign rx_en   = r_q.ctrl[0];
    assign carrier = ir_sync ^ r_q.ctrl[2];

    ir_rx_rle #(.PER_W(8), .LIM_W(16)) u_rle (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (rx_en),
        .period (r_q.period),
        .carrier(carrier),
        .limit  (r_q.limit),
        .push   (rle_push),
        .byte_o (rle_byte),
        .pkt_end(rle_end)
    );

    assign fifo_clr = bus_wr && (bus_addr == A_FCTRL) && bus_wdata[0];
    assign fifo_pop = bus_rd && (bus_addr == A_DATA);

    ir_rx_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (fifo_clr),
        .push (rle_push),
        .din  (rle_byte),
        .pop  (fifo_pop),
        .dout (fifo_dout),
        .count(fifo_cnt),
        .full (fifo_full)
    );

    always_comb begin
        if (r_q.fctrl[3:2] == 2'd0) trig_lvl = CW'(1);
        else                        trig_lvl = CW'(int'(r_q.fctrl[3:2]) * (DEPTH / 4));
    end

    always_comb begin
        sts_set = '0;
        if (rle_push) begin
            sts_set[ST_RDR] = 1'b1;
            if (fifo_full) sts_set[ST_RFO] = 1'b1;
            else if (!fifo_clr && (({1'b0, fifo_cnt} + 1'b1) >= {1'b0, trig_lvl}))
                sts_set[ST_RTR] = 1'b1;
        end
        if (rle_end) sts_set[ST_PE] = 1'b1;
        sts_clr = (bus_wr && (bus_addr == A_STATUS)) ? bus_wdata : 8'h00;

        r_d          = r_q;
        r_d.sts      = (r_q.sts & ~sts_clr) | sts_set;
        r_d.sts[3:0] = 4'h0;
        if (bus_wr) begin
            case (bus_addr)
                A_CTRL:   r_d.ctrl         = bus_wdata;
                A_PERIOD: r_d.period       = bus_wdata;
                A_IEN:    r_d.ien          = bus_wdata;
                A_FCTRL:  r_d.fctrl        = {bus_wdata[7:2], 2'b00};
                A_LIMHI:  r_d.limit[15:8]  = bus_wdata;
                A_LIMLO:  r_d.limit[7:0]   = bus_wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (bus_addr)
            A_CTRL:   bus_rdata = r_q.ctrl;
            A_PERIOD: bus_rdata = r_q.period;
            A_STATUS: bus_rdata = r_q.sts;
            A_IEN:    bus_rdata = r_q.ien;
            A_FCTRL:  bus_rdata = r_q.fctrl;
            A_LIMHI:  bus_rdata = r_q.limit[15:8];
            A_LIMLO:  bus_rdata = r_q.limit[7:0];
            A_COUNT:  bus_rdata = 8'(fifo_cnt);
            A_DATA:   bus_rdata = fifo_dout;
            default:  bus_rdata = 8'h00;
        endcase
    end

    assign sts_now = r_q.sts;
    assign irq     = |(r_q.sts & r_q.ien);
endmodule

// File: rtl/ir_rx_sampler_chk.sv
module ir_rx_sampler_chk #(
    parameter int DEPTH = 32,
    parameter int CW    = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] cnt,
    input logic [7:0]    sts,
    input logic          rle_push,
    input logic [7:0]    rle_byte,
    input logic          fclr,
    input logic          pop,
    input logic          rx_en
);
    // R7
    fifo_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

    // R7
    pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && cnt == '0 && !rle_push) |=> cnt == '0);

    // R8
    rfo_sets_rdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts[4]) |-> sts[7]);

    // R4
    pe_after_end_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts[5]) |-> $past(rle_push && rle_byte == 8'h80));

    // R12
    fifo_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fclr |=> cnt == '0);

    // R5
    no_push_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rx_en) |-> !rle_push);

    // R10
    tx_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> sts[3:0] == 4'h0);
endmodule

bind ir_rx_sampler ir_rx_sampler_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt     (fifo_cnt),
    .sts     (sts_now),
    .rle_push(rle_push),
    .rle_byte(rle_byte),
    .fclr    (fifo_clr),
    .pop     (fifo_pop),
    .rx_en   (rx_en)
);

// File: tb/ir_rx_sampler_bench.sv
module ir_rx_sampler_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ir_in = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [3:0] bus_addr = 4'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [7:0] exp_b [8];

    always #10 clk = ~clk;

    ir_rx_sampler u_ir_rx_sampler (
        .clk(clk), .rst_n(rst_n), .ir_in(ir_in),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic ir_for(input logic lvl, input int n);
        ir_in = lvl;
        repeat (n) @(negedge clk);
    endtask

    task automatic prep();
        wr(4'd0, 8'h00);
        wr(4'd4, 8'h01);
        wr(4'd2, 8'hFF);
        wr(4'd3, 8'h00);
        wr(4'd1, 8'h00);
    endtask

    task automatic check_fifo(input int n, input string tag);
        logic [7:0] v;
        rd(4'd7, v);
        chk({tag, " count"}, v, 8'(n));
        for (int i = 0; i < n; i++) begin
            rd(4'd8, v);
            chk({tag, " byte"}, v, exp_b[i]);
        end
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(4'd7, v); chk("R1 count", v, 8'h00);
        rd(4'd2, v); chk("R1 status", v, 8'h00);
        rd(4'd0, v); chk("R1 ctrl", v, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic basic_pattern(input logic [7:0] fctrl);
        ir_in = 1'b0;
        prep();
        wr(4'd4, fctrl);
        wr(4'd5, 8'h00);
        wr(4'd6, 8'd20);
        wr(4'd0, 8'h01);
        ir_for(1'b1, 5); ir_for(1'b0, 3); ir_for(1'b1, 7); ir_for(1'b0, 30);
    endtask

    task automatic t_basic();
        logic [7:0] v;
        basic_pattern(8'h00);
        exp_b[0] = 8'h85; exp_b[1] = 8'h03; exp_b[2] = 8'h87; exp_b[3] = 8'h80;
        check_fifo(4, "R2 R4 basic");
        rd(4'd2, v); chk("R4 R9 status pe+rtr", v, 8'hE0);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        chk("R11 irq masked", {7'd0, irq}, 8'h00);
        wr(4'd3, 8'h20);
        chk("R11 irq enabled", {7'd0, irq}, 8'h01);
        wr(4'd2, 8'h0F);
        rd(4'd2, v); chk("R10 low bits write no effect", v, 8'hE0);
        wr(4'd2, 8'h20);
        rd(4'd2, v); chk("R10 w1c one bit", v, 8'hC0);
        chk("R11 irq after clear", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_trig_high();
        logic [7:0] v;
        basic_pattern(8'h04);
        rd(4'd2, v); chk("R9 level 8 not reached", v, 8'hA0);
        rd(4'd7, v); chk("R9 count", v, 8'h04);
    endtask

    task automatic t_long();
        ir_in = 1'b0;
        prep();
        wr(4'd5, 8'h01);
        wr(4'd6, 8'h2C);
        wr(4'd0, 8'h01);
        ir_for(1'b1, 130); ir_for(1'b0, 320);
        exp_b[0] = 8'hFF; exp_b[1] = 8'h83; exp_b[2] = 8'h7F; exp_b[3] = 8'h7F; exp_b[4] = 8'h80;
        check_fifo(5, "R3 long runs");
    endtask

    task automatic t_inv_period();
        ir_in = 1'b1;
        prep();
        wr(4'd1, 8'd3);
        wr(4'd5, 8'h00);
        wr(4'd6, 8'd20);
        wr(4'd0, 8'h05);
        ir_for(1'b0, 40); ir_for(1'b1, 200);
        exp_b[0] = 8'h8A; exp_b[1] = 8'h80;
        check_fifo(2, "R5 R6 period+invert");
    endtask

    task automatic t_disabled();
        logic [7:0] v;
        ir_in = 1'b0;
        prep();
        for (int i = 0; i < 20; i++) ir_for(i[0] ? 1'b0 : 1'b1, 1);
        ir_in = 1'b0;
        repeat (5) @(negedge clk);
        rd(4'd7, v); chk("R5 disabled count", v, 8'h00);
        rd(4'd2, v); chk("R5 disabled status", v, 8'h00);
        rd(4'd8, v);
        rd(4'd7, v); chk("R7 pop empty", v, 8'h00);
    endtask

    task automatic t_overrun();
        logic [7:0] v;
        ir_in = 1'b0;
        prep();
        wr(4'd4, 8'h08);
        wr(4'd5, 8'h00);
        wr(4'd6, 8'h00);
        wr(4'd0, 8'h01);
        for (int i = 0; i < 40; i++) ir_for(i[0] ? 1'b0 : 1'b1, 1);
        ir_in = 1'b0;
        repeat (5) @(negedge clk);
        wr(4'd0, 8'h00);
        rd(4'd7, v); chk("R7 R8 full count", v, 8'd32);
        rd(4'd2, v); chk("R8 R9 overrun status", v, 8'hD0);
        rd(4'd8, v); chk("R7 first byte", v, 8'h81);
        rd(4'd8, v); chk("R7 second byte", v, 8'h01);
        rd(4'd7, v); chk("R7 count after pops", v, 8'd30);
        wr(4'd4, 8'h01);
        rd(4'd7, v); chk("R12 clear", v, 8'h00);
        wr(4'd4, 8'h3F);
        rd(4'd4, v); chk("R12 readback", v, 8'h3C);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_irq();
        t_trig_high();
        t_long();
        t_inv_period();
        t_disabled();
        t_overrun();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule